// File: doc/BRIEF.md
# Scroll and Address Port Register File

This block keeps the scroll and address state of a tile-based video generator. It holds a 15-bit live address (`cur_addr`), a 15-bit staging address (`tmp_addr`), a 3-bit horizontal fine scroll (`fine_x`) and a one-bit write phase. The scroll port and the address port share that phase. The CPU writes single bytes to one of three ports: control, scroll or address. Each port spreads its data bits into particular fields of the staging address. A read of the status port puts the phase back to "first write".

The block also receives the video timing position: the dot counter, a flag for the pre-render line, and the rendering enable. At two fixed dots it copies state from the staging address into the live address. At the horizontal copy dot it moves only the horizontal bits. At the vertical copy dot of the pre-render line it moves every bit. A CPU write and a timed copy can fall in the same cycle. In that case the write is applied first, and the copy then uses the staging value that was just written.

The write phase is a two-state machine. In `WR_FIRST`, the next scroll or address write is treated as a first write. In `WR_SECOND`, it is treated as a second write. There are three transitions:
- `FLIP`: a scroll or address write moves the phase to the other state.
- `CLEAR`: a status read forces `WR_FIRST`, and it takes priority over `FLIP`.
- `HOLD`: any other cycle keeps the state.

Top module: `scroll_addr_regs`

## Requirements
- R1: While reset is low, and in the first cycle after reset, `cur_addr`, `tmp_addr`, `fine_x` and `write_phase` are all zero. Bit 15 of `cur_addr` and of `tmp_addr` is always 0.
- R2: A write with `wr_sel`=2'b00 (control) sets t[11:10] to data[1:0]. It leaves the other bits of t, and the write phase, unchanged.
- R3: A write with `wr_sel`=2'b01 (scroll) while `write_phase`=0 sets t[4:0] to data[7:3] and `fine_x` to data[2:0]. No other operation changes `fine_x`.
- R4: A scroll write while `write_phase`=1 sets t[9:5] to data[7:3] and t[14:12] to data[2:0].
- R5: A write with `wr_sel`=2'b10 (address) while `write_phase`=0 sets t[13:8] to data[5:0] and clears t[14].
- R6: An address write while `write_phase`=1 sets t[7:0] to data[7:0] and loads v with the updated t. Outside these writes and the timed copies, v does not change.
- R7: Every scroll or address write inverts `write_phase`, and the two ports share this one phase. A `stat_rd` pulse forces the phase to 0 and wins over a write in the same cycle. That write is still decoded with the phase it saw.
- R8: When `render_en`=1 and `dot`=256, v[10] and v[4:0] are loaded from t and all other bits of v are kept. When `render_en`=0 nothing is copied.
- R9: When `render_en`=1, `prerender`=1 and `dot`=304, all of v is loaded from t. The same dot with `prerender`=0 copies nothing.
- R10: When a port write and a timed copy fall in one cycle, the copy uses the t value produced by that write.
- R11: A write with `wr_sel`=2'b11 changes neither t, v, `fine_x` nor the write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU byte write strobe |
| wr_sel | input | 2 | Port select: 00 control, 01 scroll, 10 address, 11 none |
| wr_data | input | 8 | Written byte |
| stat_rd | input | 1 | Status port read strobe, clears the write phase |
| dot | input | 9 | Current dot within the scanline |
| prerender | input | 1 | High on the pre-render line |
| render_en | input | 1 | Rendering enabled |
| cur_addr | output | 16 | Live address v, bit 15 always 0 |
| tmp_addr | output | 16 | Staging address t, bit 15 always 0 |
| fine_x | output | 3 | Fine horizontal scroll |
| write_phase | output | 1 | 0 = next shared-port write is first, 1 = second |

## Verification
The assertions assume the following about the inputs:
- `wr_sel`, `stat_rd`, `dot`, `prerender` and `render_en` are sampled only at the clock edge.
- The horizontal and vertical copy dots are distinct values.

The bench drives all inputs on the falling edge, so each strobe is seen as exactly one sampled cycle. It uses only dot values 0, 256 and 304, so at most one timed copy is active in any cycle. Same-cycle combinations are applied on purpose, one at a time: a status read with a write, and a copy with a write.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
    localparam int VA_W = 15;
    localparam logic [VA_W-1:0] H_MASK = 15'h041F;

    typedef enum logic [1:0] {
        PORT_CTRL   = 2'b00,
        PORT_SCROLL = 2'b01,
        PORT_ADDR   = 2'b10,
        PORT_NONE   = 2'b11
    } port_e;

    typedef enum logic {
        WR_FIRST  = 1'b0,
        WR_SECOND = 1'b1
    } wphase_e;
endpackage

// File: rtl/scroll_wr_phase.sv
module scroll_wr_phase
    import scroll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    input  logic clear,
    output logic second
);
    wphase_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_FIRST:  if (clear) state_d = WR_FIRST;  else if (flip) state_d = WR_SECOND;
            WR_SECOND: if (clear || flip) state_d = WR_FIRST;
            default:   state_d = WR_FIRST;
        endcase
    end

    always_comb begin
        second = (state_q == WR_SECOND);
    end

    p_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flip && !clear) |=> (second != $past(second)));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !second);
endmodule

// File: rtl/scroll_tmp_decode.sv
module scroll_tmp_decode
    import scroll_pkg::*;
(
    input  logic [VA_W-1:0] t_q,
    input  logic [2:0]      x_q,
    input  logic            second,
    input  logic            wr_en,
    input  port_e           sel,
    input  logic [7:0]      data,
    output logic [VA_W-1:0] t_nxt,
    output logic [2:0]      x_nxt,
    output logic            v_load,
    output logic            phase_flip
);
    always_comb begin
        t_nxt      = t_q;
        x_nxt      = x_q;
        v_load     = 1'b0;
        phase_flip = 1'b0;
        if (wr_en) begin
            unique case (sel)
                PORT_CTRL: t_nxt[11:10] = data[1:0];
                PORT_SCROLL: begin
                    phase_flip = 1'b1;
                    if (!second) begin
                        t_nxt[4:0] = data[7:3];
                        x_nxt      = data[2:0];
                    end else begin
                        t_nxt[9:5]   = data[7:3];
                        t_nxt[14:12] = data[2:0];
                    end
                end
                PORT_ADDR: begin
                    phase_flip = 1'b1;
                    if (!second) begin
                        t_nxt[13:8] = data[5:0];
                        t_nxt[14]   = 1'b0;
                    end else begin
                        t_nxt[7:0] = data;
                        v_load     = 1'b1;
                    end
                end
                PORT_NONE: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/scroll_cur_sel.sv
module scroll_cur_sel
    import scroll_pkg::*;
#(
    parameter int DOT_W     = 9,
    parameter int HCOPY_DOT = 256,
    parameter int VCOPY_DOT = 304
) (
    input  logic [VA_W-1:0]  v_q,
    input  logic [VA_W-1:0]  t_nxt,
    input  logic             v_load,
    input  logic [DOT_W-1:0] dot,
    input  logic             prerender,
    input  logic             render_en,
    output logic [VA_W-1:0]  v_nxt
);
    localparam logic [DOT_W-1:0] H_DOT = DOT_W'(HCOPY_DOT);
    localparam logic [DOT_W-1:0] V_DOT = DOT_W'(VCOPY_DOT);

    logic             h_copy, f_copy;
    logic [VA_W-1:0]  v_wr;

    always_comb begin
        h_copy = render_en && (dot == H_DOT);
        f_copy = render_en && prerender && (dot == V_DOT);
        v_wr   = v_load ? t_nxt : v_q;
        if (f_copy)      v_nxt = t_nxt;
        else if (h_copy) v_nxt = (v_wr & ~H_MASK) | (t_nxt & H_MASK);
        else             v_nxt = v_wr;
    end
endmodule

// File: rtl/scroll_addr_regs.sv
module scroll_addr_regs
    import scroll_pkg::*;
#(
    parameter int DOT_W     = 9,
    parameter int HCOPY_DOT = 256,
    parameter int VCOPY_DOT = 304
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             stat_rd,
    input  logic [DOT_W-1:0] dot,
    input  logic             prerender,
    input  logic             render_en,
    output logic [15:0]      cur_addr,
    output logic [15:0]      tmp_addr,
    output logic [2:0]       fine_x,
    output logic             write_phase
);
    localparam logic [DOT_W-1:0] H_DOT = DOT_W'(HCOPY_DOT);
    localparam logic [DOT_W-1:0] V_DOT = DOT_W'(VCOPY_DOT);

    logic [VA_W-1:0] v_q, t_q, t_nxt, v_nxt;
    logic [2:0]      x_q, x_nxt;
    logic            v_load, phase_flip, second;

    scroll_wr_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .flip   (phase_flip),
        .clear  (stat_rd),
        .second (second)
    );

    scroll_tmp_decode u_dec (
        .t_q        (t_q),
        .x_q        (x_q),
        .second     (second),
        .wr_en      (wr_en),
        .sel        (port_e'(wr_sel)),
        .data       (wr_data),
        .t_nxt      (t_nxt),
        .x_nxt      (x_nxt),
        .v_load     (v_load),
        .phase_flip (phase_flip)
    );

    scroll_cur_sel #(
        .DOT_W     (DOT_W),
        .HCOPY_DOT (HCOPY_DOT),
        .VCOPY_DOT (VCOPY_DOT)
    ) u_cur (
        .v_q       (v_q),
        .t_nxt     (t_nxt),
        .v_load    (v_load),
        .dot       (dot),
        .prerender (prerender),
        .render_en (render_en),
        .v_nxt     (v_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            t_q <= '0;
            x_q <= '0;
        end else begin
            v_q <= v_nxt;
            t_q <= t_nxt;
            x_q <= x_nxt;
        end
    end

    assign cur_addr    = {1'b0, v_q};
    assign tmp_addr    = {1'b0, t_q};
    assign fine_x      = x_q;
    assign write_phase = second;

    logic addr2, hc, fc;
    assign addr2 = wr_en && (wr_sel == 2'b10) && write_phase;
    assign hc    = render_en && (dot == H_DOT);
    assign fc    = render_en && prerender && (dot == V_DOT);

    p_v_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr2 && !hc && !fc) |=> $stable(cur_addr));
    p_v_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr2 |=> (cur_addr == tmp_addr));
    p_hcopy_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hc && !addr2) |=> (cur_addr[9:5] == $past(cur_addr[9:5]) &&
                            cur_addr[14:11] == $past(cur_addr[14:11])));
    p_full_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fc |=> (cur_addr == tmp_addr));
    p_x_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'b01 && !write_phase) |=> $stable(fine_x));
    p_ctrl_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b00 && !stat_rd) |=>
            (tmp_addr[9:0] == $past(tmp_addr[9:0]) &&
             tmp_addr[14:12] == $past(tmp_addr[14:12]) &&
             write_phase == $past(write_phase)));
    p_idle_t_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel != 2'b11) |=> $stable(tmp_addr));
endmodule

// File: tb/sim_scroll_addr_regs.sv
module sim_scroll_addr_regs;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, stat_rd, prerender, render_en;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic [8:0] dot;
    logic [15:0] cur_addr, tmp_addr;
    logic [2:0] fine_x;
    logic       write_phase;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    scroll_addr_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .stat_rd(stat_rd), .dot(dot),
        .prerender(prerender), .render_en(render_en),
        .cur_addr(cur_addr), .tmp_addr(tmp_addr), .fine_x(fine_x),
        .write_phase(write_phase)
    );

    // {sel, data, expected t, expected v, expected x, expected phase}
    localparam int NV = 12;
    localparam logic [43:0] VEC [NV] = '{
        {2'b00, 8'h00, 15'h0000, 15'h0000, 3'd0, 1'b0},
        {2'b01, 8'h7D, 15'h000F, 15'h0000, 3'd5, 1'b1},
        {2'b01, 8'h5E, 15'h616F, 15'h0000, 3'd5, 1'b0},
        {2'b10, 8'h3D, 15'h3D6F, 15'h0000, 3'd5, 1'b1},
        {2'b10, 8'hF0, 15'h3DF0, 15'h3DF0, 3'd5, 1'b0},
        {2'b10, 8'h27, 15'h27F0, 15'h3DF0, 3'd5, 1'b1},
        {2'b01, 8'h3E, 15'h64F0, 15'h3DF0, 3'd5, 1'b0},
        {2'b01, 8'h7D, 15'h64EF, 15'h3DF0, 3'd5, 1'b1},
        {2'b10, 8'h99, 15'h6499, 15'h6499, 3'd5, 1'b0},
        {2'b00, 8'h03, 15'h6C99, 15'h6499, 3'd5, 1'b0},
        {2'b11, 8'hFF, 15'h6C99, 15'h6499, 3'd5, 1'b0},
        {2'b01, 8'hFF, 15'h6C9F, 15'h6499, 3'd7, 1'b1}
    };

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(string req, logic [14:0] et, logic [14:0] ev,
                           logic [2:0] ex, logic ep);
        chk({req, " t"}, tmp_addr, {1'b0, et});
        chk({req, " v"}, cur_addr, {1'b0, ev});
        chk({req, " x"}, {13'd0, fine_x}, {13'd0, ex});
        chk({req, " phase"}, {15'd0, write_phase}, {15'd0, ep});
    endtask

    task automatic step(logic we, logic [1:0] sel, logic [7:0] d, logic sr,
                        logic [8:0] dt, logic pr, logic re);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; stat_rd = sr;
        dot = dt; prerender = pr; render_en = re;
        @(posedge clk);
        #1;
        wr_en = 1'b0; stat_rd = 1'b0; dot = 9'd0; prerender = 1'b0; render_en = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'b00; wr_data = 8'h00;
        stat_rd = 1'b0; dot = 9'd0; prerender = 1'b0; render_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk_all("R1 reset", 15'h0, 15'h0, 3'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_all("R1 after reset", 15'h0, 15'h0, 3'd0, 1'b0);

        // R2 R3 R4 R5 R6 R7 R11 table walk
        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][43:42], VEC[i][41:34], 1'b0, 9'd0, 1'b0, 1'b0);
            chk_all($sformatf("R2-6/R11 vec%0d", i), VEC[i][33:19], VEC[i][18:4],
                    VEC[i][3:1], VEC[i][0]);
        end

        // R7: status read clears the phase
        step(1'b0, 2'b00, 8'h00, 1'b1, 9'd0, 1'b0, 1'b0);
        chk_all("R7 stat read", 15'h6C9F, 15'h6499, 3'd7, 1'b0);
        // R7: read with a first scroll write, read wins
        step(1'b1, 2'b01, 8'h00, 1'b1, 9'd0, 1'b0, 1'b0);
        chk_all("R7 read+write", 15'h6C80, 15'h6499, 3'd0, 1'b0);
        step(1'b1, 2'b01, 8'h00, 1'b0, 9'd0, 1'b0, 1'b0);
        chk_all("R3 first again", 15'h6C80, 15'h6499, 3'd0, 1'b1);
        step(1'b1, 2'b01, 8'hFF, 1'b0, 9'd0, 1'b0, 1'b0);
        chk_all("R4 second", 15'h7FE0, 15'h6499, 3'd0, 1'b0);
        step(1'b1, 2'b00, 8'h01, 1'b0, 9'd0, 1'b0, 1'b0);
        chk_all("R2 ctrl", 15'h77E0, 15'h6499, 3'd0, 1'b0);

        // R8 horizontal copy
        step(1'b0, 2'b00, 8'h00, 1'b0, 9'd256, 1'b0, 1'b0);
        chk_all("R8 disabled", 15'h77E0, 15'h6499, 3'd0, 1'b0);
        step(1'b0, 2'b00, 8'h00, 1'b0, 9'd256, 1'b0, 1'b1);
        chk_all("R8 hcopy", 15'h77E0, 15'h6480, 3'd0, 1'b0);

        // R9 full copy
        step(1'b0, 2'b00, 8'h00, 1'b0, 9'd304, 1'b0, 1'b1);
        chk_all("R9 not prerender", 15'h77E0, 15'h6480, 3'd0, 1'b0);
        step(1'b0, 2'b00, 8'h00, 1'b0, 9'd304, 1'b1, 1'b1);
        chk_all("R9 full copy", 15'h77E0, 15'h77E0, 3'd0, 1'b0);

        // R10 write and copy together
        step(1'b1, 2'b00, 8'h02, 1'b0, 9'd256, 1'b0, 1'b1);
        chk_all("R10 ctrl+hcopy", 15'h7BE0, 15'h73E0, 3'd0, 1'b0);
        step(1'b1, 2'b01, 8'h38, 1'b0, 9'd304, 1'b1, 1'b1);
        chk_all("R10 scroll+full", 15'h7BE7, 15'h7BE7, 3'd0, 1'b1);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk_all("R1 mid reset", 15'h0, 15'h0, 3'd0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule